// File: doc/BRIEF.md
# SPI receive status and overflow flags

This block sits between the shift register of a serial peripheral interface and the CPU's register interface. It holds the byte the CPU reads on the receive side and keeps three flags: receive-full, overflow and mode-fault. When the shift register reports a finished byte, the block either captures the byte, or records an overflow and drops the byte, or silently drops the byte while an earlier overflow is still pending.

The CPU clears the flags only through ordered accesses. It reads the status register and then the data register to clear receive-full and overflow. It reads the status register and then writes the control register to clear mode-fault. A flag counts toward a clear only if the earlier status read saw it set. An overflow that appears between the two reads therefore survives, and the next status read shows it. The block drives a receive interrupt and one error interrupt that overflow and mode-fault share.

The serial shifting, clock generation and transmit path are not part of this block.

Top module: `spi_rx_status`

## Requirements
- R1: The status read value `stat_q` holds receive-full in bit 0. When `byte_done` pulses while receive-full and overflow are both clear, receive-full is set on the next clock and `data_q` shows `rx_byte`.
- R2: Receive-full clears on a `data_rd` pulse only if the most recent `stat_rd` before it saw receive-full set. A `data_rd` without such a status read leaves receive-full set.
- R3: Overflow is status bit 1. When `byte_done` pulses while receive-full is set and overflow is clear, overflow is set, the new byte is dropped and `data_q` keeps the earlier byte.
- R4: The `data_rd` that clears receive-full leaves overflow set, unless the preceding `stat_rd` saw overflow set, in which case overflow clears too.
- R5: While overflow is set, a `byte_done` pulse neither sets receive-full nor changes `data_q`.
- R6: If overflow becomes set between the status read and the data read, a further `stat_rd` after that data read shows overflow set.
- R7: `ctl_wdata` bit 0 is the receive interrupt enable, readable at status bit 3. `rx_irq` equals receive-full AND that enable.
- R8: `ctl_wdata` bit 1 is the error interrupt enable, readable at status bit 4. `err_irq` equals (overflow OR mode-fault) AND that enable. There is no separate enable for either flag.
- R9: Mode-fault is status bit 2. Its enable is `ctl_wdata` bit 2, readable at status bit 5. `fault_det` sets mode-fault only while that enable is set. Mode-fault clears on a `ctl_wr` that follows a `stat_rd` which saw mode-fault set.
- R10: After reset, `stat_q`, `data_q`, `rx_irq` and `err_irq` are all zero.
- R11: A `byte_done` pulse in the same cycle as a `data_rd` that clears receive-full acts as if it came after the clear. Receive-full is set again, `data_q` takes the new byte and overflow stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_done | input | 1 | Shift register finished a byte (one-cycle strobe) |
| rx_byte | input | DW | Byte from the shift register |
| fault_det | input | 1 | Mode-fault condition detected |
| stat_rd | input | 1 | CPU reads the status register |
| data_rd | input | 1 | CPU reads the data register |
| ctl_wr | input | 1 | CPU writes the control enables |
| ctl_wdata | input | 3 | Enables: [0] receive irq, [1] error irq, [2] mode-fault |
| stat_q | output | 6 | Status read value |
| data_q | output | DW | Data register read value |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Shared error interrupt |

## Verification
The bench builds the block with DW = 4, so that every byte value can pass through the capture-and-clear path in turn and each result is checked against the value sent. It then drives the awkward orderings by hand: a byte that lands between the status read and the data read, bytes that arrive while an overflow is pending, a strobe in the same cycle as the clearing read, and mode-fault with its enable on and off.

// File: rtl/spi_rx_status.sv
module spi_rx_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          fault_det,
  input  logic          stat_rd,
  input  logic          data_rd,
  input  logic          ctl_wr,
  input  logic [2:0]    ctl_wdata,
  output logic [5:0]    stat_q,
  output logic [DW-1:0] data_q,
  output logic          rx_irq,
  output logic          err_irq
);

  logic          rxf, ovf, flt;
  logic          rx_ie, err_ie, flt_en;
  logic          arm_rxf, arm_ovf, arm_flt;
  logic [DW-1:0] hold_q;

  wire clr_rxf = data_rd & arm_rxf;
  wire clr_ovf = data_rd & arm_ovf;
  wire clr_flt = ctl_wr & arm_flt;

  // flag values once this cycle's clears are applied
  wire rxf_v = rxf & ~clr_rxf;
  wire ovf_v = ovf & ~clr_ovf;

  wire take    = byte_done & ~ovf_v & ~rxf_v;
  wire overrun = byte_done & ~ovf_v & rxf_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxf     <= 1'b0;
      ovf     <= 1'b0;
      flt     <= 1'b0;
      rx_ie   <= 1'b0;
      err_ie  <= 1'b0;
      flt_en  <= 1'b0;
      arm_rxf <= 1'b0;
      arm_ovf <= 1'b0;
      arm_flt <= 1'b0;
      hold_q  <= '0;
    end else begin
      rxf <= rxf_v | take;
      ovf <= ovf_v | overrun;
      flt <= (flt & ~clr_flt) | (fault_det & flt_en);
      if (take) hold_q <= rx_byte;
      if (ctl_wr) {flt_en, err_ie, rx_ie} <= ctl_wdata;
      if (stat_rd) begin
        arm_rxf <= rxf;
        arm_ovf <= ovf;
        arm_flt <= flt;
      end else begin
        if (data_rd) begin
          arm_rxf <= 1'b0;
          arm_ovf <= 1'b0;
        end
        if (ctl_wr) arm_flt <= 1'b0;
      end
    end
  end

  assign stat_q  = {flt_en, err_ie, rx_ie, flt, ovf, rxf};
  assign data_q  = hold_q;
  assign rx_irq  = rxf & rx_ie;
  assign err_irq = (ovf | flt) & err_ie;

endmodule

// File: rtl/spi_rx_status_chk.sv
module spi_rx_status_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          byte_done,
  input logic [DW-1:0] rx_byte,
  input logic          fault_det,
  input logic          data_rd,
  input logic [5:0]    stat_q,
  input logic [DW-1:0] data_q,
  input logic          rx_irq,
  input logic          err_irq
);

  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !stat_q[0] && !stat_q[1]) |=> (stat_q[0] && data_q == $past(rx_byte)));

  a_r3_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && stat_q[0] && !data_rd) |=> (stat_q[1] && $stable(data_q)));

  a_r5_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && stat_q[1] && !data_rd) |=> ($stable(data_q) && stat_q[0] == $past(stat_q[0])));

  a_r2_rxf_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q[0]) |-> $past(data_rd));

  a_r4_ovf_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q[1]) |-> $past(data_rd));

  a_r9_fault_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[2]) |-> ($past(stat_q[5]) && $past(fault_det)));

  a_r7_rx_irq: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq == (stat_q[0] && stat_q[3]));

  a_r8_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq == ((stat_q[1] || stat_q[2]) && stat_q[4]));

endmodule

bind spi_rx_status spi_rx_status_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte),
  .fault_det(fault_det), .data_rd(data_rd), .stat_q(stat_q),
  .data_q(data_q), .rx_irq(rx_irq), .err_irq(err_irq)
);

// File: tb/tb_spi_rx_status.sv
`timescale 1ns/1ps
module tb_spi_rx_status;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          byte_done = 1'b0;
  logic [DW-1:0] rx_byte = '0;
  logic          fault_det = 1'b0;
  logic          stat_rd = 1'b0;
  logic          data_rd = 1'b0;
  logic          ctl_wr = 1'b0;
  logic [2:0]    ctl_wdata = '0;
  logic [5:0]    stat_q;
  logic [DW-1:0] data_q;
  logic          rx_irq, err_irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [5:0] seen;

  always #5 clk = ~clk;

  spi_rx_status #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte),
    .fault_det(fault_det), .stat_rd(stat_rd), .data_rd(data_rd),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .stat_q(stat_q),
    .data_q(data_q), .rx_irq(rx_irq), .err_irq(err_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic recv(input int b);
    byte_done = 1'b1; rx_byte = DW'(b);
    @(negedge clk);
    byte_done = 1'b0;
  endtask

  task automatic rd_stat(output logic [5:0] v);
    v = stat_q; stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic rd_data();
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
  endtask

  task automatic wr_ctl(input logic [2:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    eq("R10 status after reset", stat_q, 0);
    eq("R10 data after reset", data_q, 0);
    eq("R10 irqs after reset", {rx_irq, err_irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    wr_ctl(3'b001);
    eq("R7 enable readback", stat_q[3], 1);
    for (int v = 0; v < (1 << DW); v++) begin
      eq("R7 irq idle", rx_irq, 0);
      recv(v);
      eq("R1 receive-full set", stat_q[0], 1);
      eq("R1 byte captured", data_q, v);
      eq("R7 irq raised", rx_irq, 1);
      rd_stat(seen);
      eq("R2 status shows full", seen[0], 1);
      rd_data();
      eq("R2 cleared by sequence", stat_q[1:0], 0);
    end

    recv(5);
    rd_data();
    eq("R2 data read alone keeps flag", stat_q[0], 1);
    rd_stat(seen);
    rd_data();
    eq("R2 clear after status read", stat_q[0], 0);

    wr_ctl(3'b010);
    eq("R7 irq off when disabled", rx_irq, 0);
    recv(3);
    eq("R7 irq off with full set", rx_irq, 0);
    recv(9);
    eq("R3 overflow set", stat_q[1], 1);
    eq("R3 earlier byte kept", data_q, 3);
    eq("R8 error irq", err_irq, 1);
    rd_stat(seen);
    rd_data();
    eq("R4 both cleared when seen", stat_q[1:0], 0);
    eq("R8 error irq dropped", err_irq, 0);

    recv(6);
    rd_stat(seen);
    eq("R6 first read no overflow", seen[1], 0);
    recv(12);
    rd_data();
    eq("R4 data read keeps overflow", stat_q[1], 1);
    eq("R4 receive-full cleared", stat_q[0], 0);
    rd_stat(seen);
    eq("R6 second read shows overflow", seen[1], 1);
    recv(7);
    eq("R5 full stays clear", stat_q[0], 0);
    eq("R5 data unchanged", data_q, 6);
    rd_data();
    eq("R4 overflow cleared", stat_q[1], 0);
    recv(8);
    eq("R5 receive resumes", data_q, 8);
    rd_stat(seen);
    rd_data();

    recv(2);
    rd_stat(seen);
    data_rd = 1'b1; byte_done = 1'b1; rx_byte = DW'(11);
    @(negedge clk);
    data_rd = 1'b0; byte_done = 1'b0;
    eq("R11 full set again", stat_q[0], 1);
    eq("R11 no overflow", stat_q[1], 0);
    eq("R11 new byte", data_q, 11);
    rd_stat(seen);
    rd_data();

    wr_ctl(3'b010);
    fault_det = 1'b1;
    @(negedge clk);
    fault_det = 1'b0;
    eq("R9 fault ignored when disabled", stat_q[2], 0);
    eq("R8 no error irq", err_irq, 0);
    wr_ctl(3'b110);
    fault_det = 1'b1;
    @(negedge clk);
    fault_det = 1'b0;
    eq("R9 fault set", stat_q[2], 1);
    eq("R8 error irq from fault", err_irq, 1);
    wr_ctl(3'b100);
    eq("R8 irq off with enable clear", err_irq, 0);
    eq("R9 write without status read keeps", stat_q[2], 1);
    rd_stat(seen);
    wr_ctl(3'b100);
    eq("R9 fault cleared", stat_q[2], 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule